// File: doc/BRIEF.md
# Linear CCD Timing Generator

This block derives, from one master clock, every digital drive waveform a three-colour staggered linear CCD needs to read one scan line. It sends the same pulse to all three colour transfer gates. The shift registers then stand still for a guard interval. After that the two-phase shift clocks and their last-stage copies clock out the pixels. Inside the pixel stream the block places the reset-gate and clamp pulses, and it holds the resolution-select level. A downstream digitiser receives a sample strobe and a one-cycle marker at the start of each line.

Each line has four phases in a fixed order: transfer pulse, trailing guard, readout and leading guard. The leading guard of the next line then runs into its transfer pulse. At the first cycle of the transfer pulse, the block captures the configuration inputs: resolution, binning group, clamp style, transfer width, guard length and extra pixel count. A line therefore never mixes two settings. In half-resolution mode, neighbouring even pixels can be merged by skipping reset pulses. This divides the output sample rate by 2, 3 or 4.

Top module: `lccd_timing_gen`

## Requirements
- R1: The three transfer-gate outputs are always equal. They go high together once per line for max(tg_width_i, TG_MIN) cycles.
- R2: During the transfer pulse and for max(guard_i, GUARD_MIN) cycles on each side of it, the shift clocks hold with sh1_o=1 and sh2_o=0.
- R3: sh1_o and sh2_o are always complementary. In readout, sh1_o is high for the first HALF cycles of each 2*HALF-cycle pixel period. sh1_last_o and sh2_last_o always equal sh1_o and sh2_o.
- R4: sel_o is 1 in full resolution (hi_res_i=1) and 0 in half resolution. A line reads 2*ACT_PIX+extra_pix_i pixel periods in full resolution and ACT_PIX+extra_pix_i in half resolution.
- R5: The group size g is 1 in full resolution and bin_code_i+1 in half resolution (codes 0..3). rg_o pulses for one cycle in the first cycle of the first pixel of each group of g pixels. The first group starts at the first readout cycle.
- R6: Two reset pulses are never closer than one pixel period (2*HALF cycles).
- R7: Outside readout, meaning during the transfer pulse and both guards, rg_o is low and clamp_o is high.
- R8: With line_clamp_i=0, during readout clamp_o is high only in the cycle after each reset pulse. With line_clamp_i=1, clamp_o stays high for the whole line.
- R9: pix_valid_o pulses once per group, in the last cycle of the group's final pixel, or of the line's final pixel when that pixel closes a partial group.
- R10: line_start_o is high for exactly the first cycle of each transfer pulse. The line period is tg + 2*guard + pixels*2*HALF cycles.
- R11: Configuration inputs take effect only at the next line start. A change made during a line does not alter that line.
- R12: While reset is asserted, the outputs are: tg_o=0, sh1_o=1, sh2_o=0, rg_o=0, clamp_o=1, sel_o=1, pix_valid_o=0, line_start_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| hi_res_i | input | 1 | 1 selects full resolution, 0 selects half resolution |
| bin_code_i | input | 2 | half-resolution group size minus one |
| line_clamp_i | input | 1 | 1 selects per-line clamp, 0 selects per-pixel clamp |
| tg_width_i | input | TIME_W | transfer pulse width in cycles |
| guard_i | input | TIME_W | guard length in cycles |
| extra_pix_i | input | EXTRA_W | dummy and dark pixels added per line |
| tg_o | output | 3 | transfer gates for the three colours |
| sh1_o | output | 1 | shift clock phase 1 |
| sh2_o | output | 1 | shift clock phase 2 |
| sh1_last_o | output | 1 | last-stage shift clock phase 1 |
| sh2_last_o | output | 1 | last-stage shift clock phase 2 |
| rg_o | output | 1 | reset-gate clock |
| clamp_o | output | 1 | clamp clock |
| sel_o | output | 1 | resolution-select level |
| pix_valid_o | output | 1 | sample strobe for the digitiser |
| line_start_o | output | 1 | one-cycle marker at the start of a line |

## Verification
A corrupt phase counter or a wrong latched setting changes the line period and shifts the first shift-clock edge after the transfer pulse. Both are visible within the affected line, and the bench measures them line by line. A wrong group counter changes the number and spacing of reset and valid pulses inside the first group. Its first visible sign therefore appears one group period into readout. Configuration is changed at every line start, so any setting applied in mid-line shows up in the same line's measurements.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
  typedef enum logic [1:0] {
    PH_PRE  = 2'd0,
    PH_TG   = 2'd1,
    PH_POST = 2'd2,
    PH_READ = 2'd3
  } phase_e;
endpackage

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_tg_pkg::*;
#(
  parameter int ACT_PIX   = 5400,
  parameter int EXTRA_W   = 8,
  parameter int TIME_W    = 16,
  parameter int HALF      = 1,
  parameter int TG_MIN    = 200,
  parameter int GUARD_MIN = 36,
  localparam int PIX_CYC  = 2 * HALF,
  localparam int SUB_W    = (PIX_CYC > 2) ? $clog2(PIX_CYC) : 1,
  localparam int PIX_W    = $clog2(2 * ACT_PIX + (1 << EXTRA_W))
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hi_res_i,
  input  logic [1:0]         bin_code_i,
  input  logic               line_clamp_i,
  input  logic [TIME_W-1:0]  tg_width_i,
  input  logic [TIME_W-1:0]  guard_i,
  input  logic [EXTRA_W-1:0] extra_pix_i,
  output phase_e             phase_o,
  output logic [SUB_W-1:0]   sub_o,
  output logic               pix_last_o,
  output logic [2:0]         grp_size_o,
  output logic               line_clamp_o,
  output logic               sel_o,
  output logic               line_start_o
);
  phase_e             phase_q;
  logic [TIME_W-1:0]  cnt_q, tg_q, guard_q;
  logic [PIX_W-1:0]   pix_q, npix_q;
  logic [SUB_W-1:0]   sub_q;
  logic               hi_q, lclamp_q;
  logic [1:0]         bin_q;
  logic [TIME_W-1:0]  tg_eff, guard_eff;
  logic [PIX_W-1:0]   npix_eff;

  // illegal settings are raised to the minimum
  assign tg_eff    = (tg_width_i < TIME_W'(TG_MIN)) ? TIME_W'(TG_MIN) : tg_width_i;
  assign guard_eff = (guard_i < TIME_W'(GUARD_MIN)) ? TIME_W'(GUARD_MIN) : guard_i;
  assign npix_eff  = (hi_res_i ? PIX_W'(2 * ACT_PIX) : PIX_W'(ACT_PIX)) + PIX_W'(extra_pix_i);

  assign pix_last_o = (pix_q == npix_q - PIX_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_PRE;
      cnt_q    <= '0;
      pix_q    <= '0;
      sub_q    <= '0;
      tg_q     <= TIME_W'(TG_MIN);
      guard_q  <= TIME_W'(GUARD_MIN);
      npix_q   <= PIX_W'(2 * ACT_PIX);
      hi_q     <= 1'b1;
      bin_q    <= '0;
      lclamp_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_PRE: begin
          if (cnt_q == guard_q - TIME_W'(1)) begin
            phase_q  <= PH_TG;
            cnt_q    <= '0;
            tg_q     <= tg_eff;
            guard_q  <= guard_eff;
            npix_q   <= npix_eff;
            hi_q     <= hi_res_i;
            bin_q    <= bin_code_i;
            lclamp_q <= line_clamp_i;
          end else begin
            cnt_q <= cnt_q + TIME_W'(1);
          end
        end
        PH_TG: begin
          if (cnt_q == tg_q - TIME_W'(1)) begin
            phase_q <= PH_POST;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + TIME_W'(1);
          end
        end
        PH_POST: begin
          if (cnt_q == guard_q - TIME_W'(1)) begin
            phase_q <= PH_READ;
            cnt_q   <= '0;
            pix_q   <= '0;
            sub_q   <= '0;
          end else begin
            cnt_q <= cnt_q + TIME_W'(1);
          end
        end
        default: begin
          if (sub_q == SUB_W'(PIX_CYC - 1)) begin
            sub_q <= '0;
            if (pix_last_o) begin
              phase_q <= PH_PRE;
              cnt_q   <= '0;
            end else begin
              pix_q <= pix_q + PIX_W'(1);
            end
          end else begin
            sub_q <= sub_q + SUB_W'(1);
          end
        end
      endcase
    end
  end

  assign phase_o      = phase_q;
  assign sub_o        = sub_q;
  assign grp_size_o   = hi_q ? 3'd1 : ({1'b0, bin_q} + 3'd1);
  assign line_clamp_o = lclamp_q;
  assign sel_o        = hi_q;
  assign line_start_o = (phase_q == PH_TG) && (cnt_q == '0);
endmodule

// File: rtl/ccd_pix_clk.sv
module ccd_pix_clk
  import ccd_tg_pkg::*;
#(
  parameter int HALF     = 1,
  localparam int PIX_CYC = 2 * HALF,
  localparam int SUB_W   = (PIX_CYC > 2) ? $clog2(PIX_CYC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic             pix_last_i,
  input  logic [2:0]       grp_size_i,
  input  logic             line_clamp_i,
  output logic             sh1_o,
  output logic             sh2_o,
  output logic             rg_o,
  output logic             clamp_o,
  output logic             valid_o
);
  logic       reading, pix_end, grp_end, grp_head;
  logic [1:0] grp_q;

  assign reading  = (phase_i == PH_READ);
  assign pix_end  = reading && (sub_i == SUB_W'(PIX_CYC - 1));
  assign grp_end  = ({1'b0, grp_q} == grp_size_i - 3'd1);
  assign grp_head = reading && (grp_q == 2'd0);

  // pixel index within the current merge group
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          grp_q <= '0;
    else if (!reading)    grp_q <= '0;
    else if (pix_end)     grp_q <= grp_end ? 2'd0 : grp_q + 2'd1;
  end

  assign sh1_o   = !reading || (sub_i < SUB_W'(HALF));
  assign sh2_o   = !sh1_o;
  assign rg_o    = grp_head && (sub_i == '0);
  assign clamp_o = !reading || line_clamp_i || (grp_head && (sub_i == SUB_W'(1)));
  assign valid_o = pix_end && (grp_end || pix_last_i);
endmodule

// File: rtl/lccd_timing_gen.sv
module lccd_timing_gen
  import ccd_tg_pkg::*;
#(
  parameter int ACT_PIX   = 5400,
  parameter int EXTRA_W   = 8,
  parameter int TIME_W    = 16,
  parameter int HALF      = 1,
  parameter int TG_MIN    = 200,
  parameter int GUARD_MIN = 36,
  localparam int PIX_CYC  = 2 * HALF,
  localparam int SUB_W    = (PIX_CYC > 2) ? $clog2(PIX_CYC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hi_res_i,
  input  logic [1:0]         bin_code_i,
  input  logic               line_clamp_i,
  input  logic [TIME_W-1:0]  tg_width_i,
  input  logic [TIME_W-1:0]  guard_i,
  input  logic [EXTRA_W-1:0] extra_pix_i,
  output logic [2:0]         tg_o,
  output logic               sh1_o,
  output logic               sh2_o,
  output logic               sh1_last_o,
  output logic               sh2_last_o,
  output logic               rg_o,
  output logic               clamp_o,
  output logic               sel_o,
  output logic               pix_valid_o,
  output logic               line_start_o
);
  phase_e           phase;
  logic [SUB_W-1:0] sub;
  logic             pix_last, lclamp;
  logic [2:0]       grp_size;
  logic             sh1, sh2;

  ccd_line_seq #(
    .ACT_PIX(ACT_PIX), .EXTRA_W(EXTRA_W), .TIME_W(TIME_W),
    .HALF(HALF), .TG_MIN(TG_MIN), .GUARD_MIN(GUARD_MIN)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hi_res_i(hi_res_i), .bin_code_i(bin_code_i), .line_clamp_i(line_clamp_i),
    .tg_width_i(tg_width_i), .guard_i(guard_i), .extra_pix_i(extra_pix_i),
    .phase_o(phase), .sub_o(sub), .pix_last_o(pix_last),
    .grp_size_o(grp_size), .line_clamp_o(lclamp),
    .sel_o(sel_o), .line_start_o(line_start_o)
  );

  ccd_pix_clk #(.HALF(HALF)) u_pix (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .phase_i(phase), .sub_i(sub), .pix_last_i(pix_last),
    .grp_size_i(grp_size), .line_clamp_i(lclamp),
    .sh1_o(sh1), .sh2_o(sh2), .rg_o(rg_o), .clamp_o(clamp_o), .valid_o(pix_valid_o)
  );

  // one gate per colour, identical timing
  for (genvar c = 0; c < 3; c++) begin : g_tg
    assign tg_o[c] = (phase == PH_TG);
  end

  assign sh1_o      = sh1;
  assign sh2_o      = sh2;
  assign sh1_last_o = sh1;
  assign sh2_last_o = sh2;
endmodule

// File: rtl/lccd_timing_gen_chk.sv
module lccd_timing_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] tg_o,
  input logic       sh1_o,
  input logic       sh2_o,
  input logic       sh1_last_o,
  input logic       sh2_last_o,
  input logic       rg_o,
  input logic       clamp_o,
  input logic       sel_o,
  input logic       pix_valid_o,
  input logic       line_start_o
);
  a_r1_gates_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tg_o == 3'b000) || (tg_o == 3'b111));
  a_r2_still_in_tg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tg_o[0] |-> (sh1_o && !sh2_o));
  a_r3_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh1_o != sh2_o);
  a_r3_last_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh1_last_o == sh1_o) && (sh2_last_o == sh2_o));
  a_r6_rg_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_o |=> !rg_o);
  a_r7_tg_rg_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tg_o[0] |-> (!rg_o && clamp_o));
  a_r9_no_valid_in_tg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (tg_o == 3'b000));
  a_r10_start_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tg_o[0]) |-> line_start_o);
  a_r10_start_is_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> $rose(tg_o[0]));
  a_r11_sel_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_o) |-> line_start_o);
endmodule

bind lccd_timing_gen lccd_timing_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tg_o(tg_o), .sh1_o(sh1_o), .sh2_o(sh2_o),
  .sh1_last_o(sh1_last_o), .sh2_last_o(sh2_last_o), .rg_o(rg_o), .clamp_o(clamp_o),
  .sel_o(sel_o), .pix_valid_o(pix_valid_o), .line_start_o(line_start_o)
);

// File: tb/lccd_timing_gen_tb.sv
module lccd_timing_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACT  = 5;
  localparam int EXW  = 2;
  localparam int TW   = 8;
  localparam int HALF = 2;
  localparam int PC   = 2 * HALF;
  localparam int TGM  = 4;
  localparam int GDM  = 3;
  localparam int NL   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_res, lclamp;
  logic [1:0] bin;
  logic [TW-1:0] tgw, gdw;
  logic [EXW-1:0] extra;
  logic [2:0] tg;
  logic sh1, sh2, sh1l, sh2l, rg, clamp, sel, valid, lstart;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lccd_timing_gen #(
    .ACT_PIX(ACT), .EXTRA_W(EXW), .TIME_W(TW), .HALF(HALF), .TG_MIN(TGM), .GUARD_MIN(GDM)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hi_res_i(hi_res), .bin_code_i(bin), .line_clamp_i(lclamp),
    .tg_width_i(tgw), .guard_i(gdw), .extra_pix_i(extra),
    .tg_o(tg), .sh1_o(sh1), .sh2_o(sh2), .sh1_last_o(sh1l), .sh2_last_o(sh2l),
    .rg_o(rg), .clamp_o(clamp), .sel_o(sel), .pix_valid_o(valid), .line_start_o(lstart)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int c_hi(int k);    return (k % 3 == 0) ? 1 : 0; endfunction
  function automatic int c_bin(int k);   return k % 4; endfunction
  function automatic int c_lc(int k);    return (k / 2) % 2; endfunction
  function automatic int c_tg(int k);    return (k % 5 == 0) ? 1 : TGM + k % 3; endfunction
  function automatic int c_gd(int k);    return (k % 4 == 2) ? 0 : GDM + k % 2; endfunction
  function automatic int c_ex(int k);    return k % 3; endfunction

  task automatic apply(input int k);
    hi_res = c_hi(k)[0];
    bin    = 2'(c_bin(k));
    lclamp = c_lc(k)[0];
    tgw    = TW'(c_tg(k));
    gdw    = TW'(c_gd(k));
    extra  = EXW'(c_ex(k));
  endtask

  // called with the line_start cycle currently sampled; returns at the next one
  task automatic measure(input int k);
    int e_tg, e_gd, e_np, e_g, e_ng, e_len;
    int idx, tgc, bad_tg, bad_sh, bad_out, sel_bad, rises, f_sh2, l_sh2;
    int nrg, f_rg, l_rg, gap_min, ncl, nval, f_val;
    bit p_sh2;
    e_tg = (c_tg(k) < TGM) ? TGM : c_tg(k);
    e_gd = (c_gd(k) < GDM) ? GDM : c_gd(k);
    e_np = (c_hi(k) == 1 ? 2 * ACT : ACT) + c_ex(k);
    e_g  = (c_hi(k) == 1) ? 1 : c_bin(k) + 1;
    e_ng = (e_np + e_g - 1) / e_g;
    e_len = e_tg + 2 * e_gd + e_np * PC;
    idx = 0; tgc = 0; bad_tg = 0; bad_sh = 0; bad_out = 0; sel_bad = 0; rises = 0;
    f_sh2 = -1; l_sh2 = -1; nrg = 0; f_rg = -1; l_rg = -1; gap_min = 1000;
    ncl = 0; nval = 0; f_val = -1; p_sh2 = 1'b0;
    apply(k + 1);  // next line's setting, changed mid-line (R11)
    forever begin
      if (tg == 3'b111) tgc++;
      if (tg != 3'b111 && tg != 3'b000) bad_tg++;
      if (sh1 == sh2 || sh1l != sh1 || sh2l != sh2) bad_sh++;
      if (sh2 && !p_sh2) rises++;
      if (sh2 && f_sh2 < 0) f_sh2 = idx;
      if (sh2) l_sh2 = idx;
      p_sh2 = sh2;
      if (rg) begin
        nrg++;
        if (f_rg < 0) f_rg = idx;
        if (l_rg >= 0 && idx - l_rg < gap_min) gap_min = idx - l_rg;
        l_rg = idx;
      end
      if ((tg != 3'b000) && (rg || !clamp)) bad_out++;
      if (idx < e_tg + e_gd && rg) bad_out++;
      if (clamp) ncl++;
      if (valid) begin
        nval++;
        if (f_val < 0) f_val = idx;
      end
      if (sel != c_hi(k)[0]) sel_bad++;
      @(negedge clk);
      idx++;
      if (lstart || done) break;
    end
    check("R10 line period", idx, e_len);
    check("R1 tg width", tgc, e_tg);
    check("R1 tg equal", bad_tg, 0);
    check("R2 trailing guard", f_sh2, e_tg + e_gd + HALF);
    check("R2 leading guard", idx - 1 - l_sh2, e_gd);
    check("R3 phase pattern", bad_sh, 0);
    check("R4 pixel count", rises, e_np);
    check("R4 R11 select held", sel_bad, 0);
    check("R5 reset count", nrg, e_ng);
    check("R5 first reset", f_rg, e_tg + e_gd);
    if (e_ng > 1) begin
      check("R5 group spacing", gap_min, e_g * PC);
      check("R6 reset rate", (gap_min >= PC) ? 1 : 0, 1);
    end
    check("R7 idle outputs", bad_out, 0);
    check("R8 clamp cycles", ncl, (c_lc(k) == 1) ? e_len : e_tg + 2 * e_gd + e_ng);
    check("R9 valid count", nval, e_ng);
    check("R9 first valid", f_val, e_tg + e_gd + ((e_g < e_np) ? e_g : e_np) * PC - 1);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    apply(0);
    repeat (3) @(negedge clk);
    check("R12 tg", int'(tg), 0);
    check("R12 sh1", int'(sh1), 1);
    check("R12 sh2", int'(sh2), 0);
    check("R12 rg", int'(rg), 0);
    check("R12 clamp", int'(clamp), 1);
    check("R12 sel", int'(sel), 1);
    check("R12 valid", int'(valid), 0);
    check("R12 line start", int'(lstart), 0);
    rst_n = 1'b1;
    @(negedge clk);
    while (!lstart) @(negedge clk);
    for (int k = 0; k < NL; k++) measure(k);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule